// File: doc/BRIEF.md
# SDRAM Column Burst and Read-Latency Sequencer

This block is the column-side control of a four-bank synchronous DRAM. It takes column commands (read, write) that have already been decoded, with a column address and a bank number. From them it produces one column address per clock for the storage array, a read or write strobe for each beat, and an output-enable that places read data on the data bus a programmable number of clocks after the read command. A mode-set command reloads a small configuration register from the address bus. That register selects the CAS latency, the burst length and whether the burst wraps sequentially or by interleaving. A per-beat mask input suppresses individual data transfers. For reads it acts with a two-clock delay. For writes it acts on the same clock.

Every input is sampled on the rising clock edge. A low clock-enable on one edge freezes the whole block on the next edge. A new column command cuts short any burst in progress. Each output comes from a register.

Top module: `sdram_burst_ctl`

## Requirements
- R1: Synchronous active-high reset clears `arr_rd`, `arr_wr` and `data_oe`. It sets the mode to burst length 4, sequential order and CAS latency 2.
- R2: The mode-set opcode (`op`=3) loads the mode from `addr`. Bits [2:0] give the burst length as 2 to the power of the code (code 1, 2 or 3 gives 2, 4 or 8). Bit 3 set selects interleaved order. Bits [6:4] give the CAS latency (code 2 or 3).
- R3: A mode-set whose burst code is not 1, 2 or 3, or whose latency code is not 2 or 3, leaves the whole mode unchanged.
- R4: In sequential order, beat k of a burst of length BL addresses the start column with its low log2(BL) bits replaced by (start + k) mod BL.
- R5: In interleaved order, beat k addresses the start column with its low log2(BL) bits replaced by (start XOR k).
- R6: A read (`op`=1) or write (`op`=2) sampled at edge T0 drives beat k on `arr_col` for k = 0..BL-1 from edge T0+k. `arr_bank` holds the command's bank throughout. The strobe drops after the last beat.
- R7: For a read with CAS latency CL, `data_oe` is high for beat k from edge T0+CL-1+k, so that the data is captured at edge T0+CL+k. Writes never raise `data_oe`.
- R8: `dqm` high at edge E during a read clears the `data_oe` slot that starts at edge E+1. The data captured two clocks later is masked. The array read and the address sequence continue.
- R9: `dqm` high at the edge where a write beat is issued suppresses `arr_wr` for that beat only. The address still advances.
- R10: A read or write sampled while a burst is running abandons the old burst. It starts a new burst at the new column, bank and direction from that same edge.
- R11: `cke` low at edge E makes edge E+1 a no-op. Every output and internal state holds, and commands at that edge are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable; low masks the following edge |
| op | input | 2 | Command: 0 none, 1 read, 2 write, 3 mode-set |
| addr | input | 12 | Column address (low 10 bits) or mode code (low 7 bits) |
| bank | input | 2 | Bank number of a column command |
| dqm | input | 1 | Data mask |
| arr_col | output | 10 | Column address presented to the array |
| arr_bank | output | 2 | Bank presented to the array |
| arr_rd | output | 1 | Array read strobe for the current beat |
| arr_wr | output | 1 | Array write strobe for the current beat, after masking |
| data_oe | output | 1 | Read data output enable |

## Verification
The address generator is driven with a table of start columns. Some have low bits of 0, some mid-block values and some all-ones, each tried under every burst length in both orders. This separates a true wrap inside the aligned block from a carry into the upper column bits, and separates addition from XOR. At an all-ones start, the two orders give opposite sequences (descending versus 7,0,1,...). Directed runs cover latency 3 against 2, read and write masking on a single middle beat, a write that cuts into a read with a change of bank, a one-edge clock-enable gap, and two kinds of illegal mode code.

// File: rtl/sdram_bc_pkg.sv
package sdram_bc_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_MODE  = 2'd3
  } op_e;

  typedef struct packed {
    logic       cl3;     // 1: latency 3, 0: latency 2
    logic       ilv;     // 1: interleaved wrap
    logic [3:0] bl_len;  // 2, 4 or 8
  } mode_t;
endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_bc_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  output mode_t             mode
);
  logic bl_ok, cl_ok;

  always_comb begin
    bl_ok = (code[2:0] == 3'd1) || (code[2:0] == 3'd2) || (code[2:0] == 3'd3);
    cl_ok = (code[6:4] == 3'd2) || (code[6:4] == 3'd3);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode.cl3    <= 1'b0;
      mode.ilv    <= 1'b0;
      mode.bl_len <= 4'd4;
    end else if (en && load && bl_ok && cl_ok) begin
      mode.cl3    <= (code[6:4] == 3'd3);
      mode.ilv    <= code[3];
      mode.bl_len <= 4'd1 << code[1:0];
    end
  end

  // R3
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(mode.bl_len) == 1) && (mode.bl_len != 4'd1));
endmodule

// File: rtl/sdram_burst_gen.sv
module sdram_burst_gen #(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2,
  parameter int BLW    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start,
  input  logic              start_wr,
  input  logic [COL_W-1:0]  col,
  input  logic [BANK_W-1:0] bank_in,
  input  logic              dqm,
  input  logic [BLW:0]      bl_len,
  input  logic              ilv,
  output logic [COL_W-1:0]  arr_col,
  output logic [BANK_W-1:0] arr_bank,
  output logic              arr_rd,
  output logic              arr_wr
);
  logic              active, wr_q;
  logic [COL_W-1:0]  start_q;
  logic [BLW-1:0]    cnt, mask, low;
  logic [COL_W-1:0]  nxt_col;

  always_comb begin
    mask = BLW'(bl_len - 1'b1);
    if (ilv) low = (start_q[BLW-1:0] ^ cnt) & mask;
    else     low = (start_q[BLW-1:0] + cnt) & mask;
    nxt_col = (start_q & ~COL_W'(mask)) | COL_W'(low);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      wr_q     <= 1'b0;
      start_q  <= '0;
      cnt      <= '0;
      arr_col  <= '0;
      arr_bank <= '0;
      arr_rd   <= 1'b0;
      arr_wr   <= 1'b0;
    end else if (en) begin
      if (start) begin
        active   <= 1'b1;
        wr_q     <= start_wr;
        start_q  <= col;
        cnt      <= BLW'(1);
        arr_col  <= col;
        arr_bank <= bank_in;
        arr_rd   <= !start_wr;
        arr_wr   <= start_wr && !dqm;
      end else if (active) begin
        arr_col <= nxt_col;
        arr_rd  <= !wr_q;
        arr_wr  <= wr_q && !dqm;
        cnt     <= cnt + 1'b1;
        if (cnt == mask) active <= 1'b0;
      end else begin
        arr_rd <= 1'b0;
        arr_wr <= 1'b0;
      end
    end
  end

  // R4
  wrap_block_chk: assert property (@(posedge clk) disable iff (rst)
    (en && active && !start) |=> (arr_col[COL_W-1:BLW] == start_q[COL_W-1:BLW]));

  // R9
  wr_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (en && dqm) |=> !arr_wr);
endmodule

// File: rtl/sdram_rd_oe.sv
module sdram_rd_oe (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rd_beat,
  input  logic cl3,
  input  logic dqm,
  output logic data_oe
);
  logic rd_d1, dqm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_d1   <= 1'b0;
      dqm_q   <= 1'b0;
      data_oe <= 1'b0;
    end else if (en) begin
      rd_d1   <= rd_beat;
      dqm_q   <= dqm;
      data_oe <= (cl3 ? rd_d1 : rd_beat) && !dqm_q;
    end
  end

  // R7
  oe_src_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> ($past(rd_beat) || $past(rd_beat, 2)));
endmodule

// File: rtl/sdram_burst_ctl.sv
module sdram_burst_ctl
  import sdram_bc_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  parameter int MAX_BL = 8,
  localparam int BLW    = $clog2(MAX_BL),
  localparam int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  input  logic              dqm,
  output logic [COL_W-1:0]  arr_col,
  output logic [BANK_W-1:0] arr_bank,
  output logic              arr_rd,
  output logic              arr_wr,
  output logic              data_oe
);
  op_e   cmd;
  logic  en, start;
  mode_t mode;

  always_comb begin
    cmd   = op_e'(op);
    start = (cmd == OP_READ) || (cmd == OP_WRITE);
  end

  always_ff @(posedge clk) begin
    if (rst) en <= 1'b1;
    else     en <= cke;
  end

  sdram_mode_reg #(.CODE_W(CODE_W)) u_mode (
    .clk(clk), .rst(rst), .en(en), .load(cmd == OP_MODE),
    .code(addr[CODE_W-1:0]), .mode(mode)
  );

  sdram_burst_gen #(.COL_W(COL_W), .BANK_W(BANK_W), .BLW(BLW)) u_burst (
    .clk(clk), .rst(rst), .en(en), .start(start), .start_wr(cmd == OP_WRITE),
    .col(addr[COL_W-1:0]), .bank_in(bank), .dqm(dqm),
    .bl_len(mode.bl_len[BLW:0]), .ilv(mode.ilv),
    .arr_col(arr_col), .arr_bank(arr_bank), .arr_rd(arr_rd), .arr_wr(arr_wr)
  );

  sdram_rd_oe u_oe (
    .clk(clk), .rst(rst), .en(en), .rd_beat(arr_rd), .cl3(mode.cl3),
    .dqm(dqm), .data_oe(data_oe)
  );

  // R11
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(arr_col) && $stable(arr_rd) && $stable(arr_wr) && $stable(data_oe)));
endmodule

// File: tb/sim_sdram_burst_ctl.sv
module sim_sdram_burst_ctl;
  logic       clk, rst, cke, dqm;
  logic [1:0] op;
  logic [11:0] addr;
  logic [1:0] bank;
  logic [9:0] arr_col;
  logic [1:0] arr_bank;
  logic       arr_rd, arr_wr, data_oe;
  int checks = 0, fails = 0;

  sdram_burst_ctl u0 (
    .clk(clk), .rst(rst), .cke(cke), .op(op), .addr(addr), .bank(bank), .dqm(dqm),
    .arr_col(arr_col), .arr_bank(arr_bank), .arr_rd(arr_rd), .arr_wr(arr_wr),
    .data_oe(data_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {mode code, start column, beat low bits one nibble each, beat 0 leftmost}
  localparam logic [48:0] VEC [10] = '{
    {7'h23, 10'h0D5, 32'h5670_1234},
    {7'h2B, 10'h0D5, 32'h5476_1032},
    {7'h22, 10'h3FE, 32'h2301_0000},
    {7'h2A, 10'h3FE, 32'h2301_0000},
    {7'h2A, 10'h001, 32'h1032_0000},
    {7'h22, 10'h001, 32'h1230_0000},
    {7'h21, 10'h011, 32'h1000_0000},
    {7'h29, 10'h010, 32'h0100_0000},
    {7'h2B, 10'h3FF, 32'h7654_3210},
    {7'h23, 10'h3FF, 32'h7012_3456}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic set_mode(input logic [6:0] code);
    op = 2'd3; addr = {5'd0, code};
    step();
    op = 2'd0;
    step();
  endtask

  task automatic run_read(input logic [9:0] col, input logic [1:0] bk, input int n,
                          input int cl, input logic [31:0] seq, input string req);
    op = 2'd1; addr = {2'd0, col}; bank = bk;
    step();
    op = 2'd0;
    for (int i = 0; i < n + cl; i++) begin
      check(req, arr_rd, i < n);
      if (i < n) begin
        check(req, arr_col, (col & ~10'(n - 1)) | 10'((seq >> (28 - 4 * i)) & 32'hF));
        check("R6", arr_bank, bk);
      end
      check("R7", data_oe, (i >= cl - 1) && (i < cl - 1 + n));
      step();
    end
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1; cke = 1; op = 0; addr = 0; bank = 0; dqm = 0;
    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    check("R1", arr_rd, 0);
    check("R1", arr_wr, 0);
    check("R1", data_oe, 0);
    // R1 default mode: BL4 sequential, latency 2
    run_read(10'h006, 2'd1, 4, 2, 32'h2301_0000, "R1");

    // R2 R4 R5 table of address orders
    for (int v = 0; v < 10; v++) begin
      set_mode(VEC[v][48:42]);
      run_read(VEC[v][41:32], 2'(v), 1 << VEC[v][44:42], 2, VEC[v][31:0],
               VEC[v][45] ? "R5" : "R4");
    end

    // R7 latency 3
    set_mode(7'h32);
    run_read(10'h040, 2'd2, 4, 3, 32'h0123_0000, "R7");

    // R3 illegal burst code, then illegal latency code: mode stays BL4 CL3
    set_mode(7'h37);
    run_read(10'h081, 2'd0, 4, 3, 32'h1230_0000, "R3");
    set_mode(7'h42);
    run_read(10'h081, 2'd0, 4, 3, 32'h1230_0000, "R3");

    // R8 read mask, latency 2, BL4
    set_mode(7'h22);
    op = 2'd1; addr = 12'h100; bank = 0;
    step();
    op = 2'd0; dqm = 1;
    check("R8", data_oe, 0);
    step();
    dqm = 0;
    check("R8", data_oe, 1);
    check("R8", arr_rd, 1);
    step(); check("R8", data_oe, 0); check("R8", arr_col, 10'h102);
    step(); check("R8", data_oe, 1);
    step(); check("R8", data_oe, 1);
    step(); check("R8", data_oe, 0);

    // R9 write mask on third beat
    op = 2'd2; addr = 12'h204; bank = 3;
    step();
    op = 2'd0;
    check("R9", arr_wr, 1); check("R9", arr_col, 10'h204); check("R6", arr_bank, 3);
    step(); check("R9", arr_wr, 1); check("R9", arr_col, 10'h205);
    dqm = 1;
    step(); check("R9", arr_wr, 0); check("R9", arr_col, 10'h206);
    dqm = 0;
    step(); check("R9", arr_wr, 1); check("R9", arr_col, 10'h207);
    check("R7", data_oe, 0);
    step(); check("R9", arr_wr, 0);

    // R10 write cuts into a BL8 read
    set_mode(7'h23);
    op = 2'd1; addr = 12'h100; bank = 0;
    step();
    op = 2'd0;
    step(); check("R10", arr_col, 10'h101);
    step(); check("R10", arr_col, 10'h102);
    op = 2'd2; addr = 12'h205; bank = 2;
    step();
    op = 2'd0;
    check("R10", arr_col, 10'h205); check("R10", arr_wr, 1);
    check("R10", arr_rd, 0); check("R10", arr_bank, 2);
    step(); check("R10", arr_col, 10'h206);
    step(); check("R10", arr_col, 10'h207);
    step(); check("R10", arr_col, 10'h200); check("R10", arr_wr, 1);
    repeat (8) step();

    // R11 clock-enable gap
    set_mode(7'h22);
    op = 2'd1; addr = 12'h300; bank = 1;
    step();
    op = 2'd0; cke = 0;
    check("R11", arr_col, 10'h300);
    step();
    cke = 1;
    check("R11", arr_col, 10'h301);
    op = 2'd2; addr = 12'h3A0;  // arrives at the masked edge
    step();
    op = 2'd0;
    check("R11", arr_col, 10'h301); check("R11", arr_rd, 1); check("R11", arr_wr, 0);
    step(); check("R11", arr_col, 10'h302); check("R11", arr_rd, 1);
    repeat (6) step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule